// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits beside a receive MAC and decides, from the first six bytes of each incoming frame, whether the frame is kept or flushed from the receive FIFO. The address bytes arrive one per clock, qualified by a byte-valid signal, and the first one is flagged by a start-of-frame strobe. While the bytes stream in, the block folds them into a CRC-32 and assembles the 48-bit destination address. One cycle after the sixth byte it raises a single-cycle decision strobe together with an accept flag.

The decision applies the following checks. A unicast destination is kept if it equals the programmed station address. Failing that, a bit of a 64-entry unicast hash table must be set. A multicast destination may be the broadcast address or the flow-control pause address, and each of these has its own rule. Any other multicast destination is looked up in a separate 64-entry multicast hash table. A promiscuous setting overrides all of these checks. All settings are plain inputs and are held steady while a frame's address is arriving.

Top module: `rx_addr_filter`

## Requirements
- R1: The multicast/unicast flag is bit 0 of the first address byte received (a value of 1 means multicast), and it selects which rule set applies. A unicast rule never applies to a multicast address.
- R2: The hash index is bits 31..26 of a 32-bit CRC register. The register starts at all ones at the first address byte. For each of the six bytes, in arrival order, it is updated least significant bit first with the reflected polynomial 0xEDB88320. No final inversion is applied.
- R3: Hash index bit 5 selects the upper 32-bit half of a table (value 1) or the lower half (value 0). Index bits 4..0 select the bit within that half. The frame is accepted when that bit is 1 and rejected when it is 0.
- R4: A unicast address equal to `stationAddr` is accepted. Byte 0 of `stationAddr` (bits 7..0) is compared with the first byte received, and so on up to bits 47..40. Any other unicast address is decided by the unicast hash table alone.
- R5: The pause address 01-80-C2-00-00-01 (first byte 0x01) is accepted when `flowCtrlEn` is 1 and rejected when it is 0. The multicast hash table plays no part in this decision.
- R6: The broadcast address FF-FF-FF-FF-FF-FF is accepted whatever the table contents, unless `bcastReject` is 1, in which case it is rejected.
- R7: When `promiscEn` is 1, every decision accepts.
- R8: `decValid` is high for exactly one cycle, the cycle after the clock edge that takes in the sixth address byte. It is low in every other cycle, including after reset. `decAccept` is meaningful while `decValid` is high.
- R9: A byte with both `sof` and `byteValid` high always starts a new address, even in the middle of one. Bytes that arrive after the sixth and before the next start of frame produce no decision.
- R10: Cycles with `byteValid` low are ignored. Gaps between address bytes do not change the decision; they only move it later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | Qualifies `byteData` |
| sof | input | 1 | Marks the first address byte of a frame |
| byteData | input | 8 | Received byte |
| stationAddr | input | 48 | Station address, first byte in bits 7..0 |
| uniHashHi | input | 32 | Unicast hash table, entries 63..32 |
| uniHashLo | input | 32 | Unicast hash table, entries 31..0 |
| mcHashHi | input | 32 | Multicast hash table, entries 63..32 |
| mcHashLo | input | 32 | Multicast hash table, entries 31..0 |
| flowCtrlEn | input | 1 | Accept the pause address |
| bcastReject | input | 1 | Reject the broadcast address |
| promiscEn | input | 1 | Accept every frame |
| decValid | output | 1 | One-cycle decision strobe |
| decAccept | output | 1 | 1 = keep frame, 0 = flush |

## Verification
The assertions compare the decision with the settings as they stood one cycle earlier. They therefore assume that the station address, the two hash tables and the three mode bits do not change between the sixth byte and the decision strobe. The stimulus changes settings only while no address is in flight: it finishes each frame and lets the decision cycle pass before reprogramming anything. The assertions also assume that `sof` only ever comes together with `byteValid`, and the stimulus never drives one without the other.

// File: rtl/rx_filt_pkg.sv
package rx_filt_pkg;
  localparam int ADDR_BYTES = 6;
  localparam int BYTE_W     = 8;
  localparam int ADDR_W     = ADDR_BYTES * BYTE_W;
  localparam int CRC_W      = 32;
  localparam int HASH_BITS  = 6;
  localparam int HALF_W     = 32;
  localparam logic [CRC_W-1:0]  CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [ADDR_W-1:0] PAUSE_ADDR    = 48'h010000C28001;

  typedef struct packed {
    logic initCrc;
    logic shiftByte;
    logic lastByte;
  } filt_strobe_t;
endpackage

// File: rtl/rx_filt_ctrl.sv
module rx_filt_ctrl
  import rx_filt_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         byteValid,
  input  logic         sof,
  output filt_strobe_t strobe
);
  localparam int CNT_W = $clog2(ADDR_BYTES + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(ADDR_BYTES);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(ADDR_BYTES - 1);
  localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

  logic [CNT_W-1:0] byteCnt, byteCntNext;

  always_comb begin
    strobe      = '0;
    byteCntNext = byteCnt;
    if (byteValid && sof) begin
      strobe.initCrc   = 1'b1;
      strobe.shiftByte = 1'b1;
      strobe.lastByte  = (ADDR_BYTES == 1);
      byteCntNext      = ONE_CNT;
    end else if (byteValid && byteCnt != '0 && byteCnt < FULL_CNT) begin
      strobe.shiftByte = 1'b1;
      strobe.lastByte  = (byteCnt == LAST_CNT);
      byteCntNext      = byteCnt + ONE_CNT;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) byteCnt <= '0;
    else       byteCnt <= byteCntNext;
  end

  // R9: the byte counter never runs past the address length
  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rstN)
    byteCnt <= FULL_CNT);

  // R10: a cycle without byteValid leaves the count untouched
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !byteValid |=> $stable(byteCnt));
endmodule

// File: rtl/rx_filt_dp.sv
module rx_filt_dp
  import rx_filt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  filt_strobe_t      strobe,
  input  logic [BYTE_W-1:0] byteData,
  input  logic [ADDR_W-1:0] stationAddr,
  input  logic [HALF_W-1:0] uniHashHi,
  input  logic [HALF_W-1:0] uniHashLo,
  input  logic [HALF_W-1:0] mcHashHi,
  input  logic [HALF_W-1:0] mcHashLo,
  input  logic              flowCtrlEn,
  input  logic              bcastReject,
  input  logic              promiscEn,
  output logic              decValid,
  output logic              decAccept
);
  localparam int SEL_W = HASH_BITS - 1;

  logic [CRC_W-1:0]     crcReg, crcBase, crcNext;
  logic [ADDR_W-1:0]    addrReg, addrNext;
  logic [HASH_BITS-1:0] hashIdx;
  logic [SEL_W-1:0]     bitSel;
  logic                 isGroup, uniHit, mcHit, verdict;

  function automatic logic [CRC_W-1:0] crcByte(input logic [CRC_W-1:0] c,
                                                input logic [BYTE_W-1:0] d);
    logic [CRC_W-1:0] r;
    r = c;
    for (int i = 0; i < BYTE_W; i++)
      r = (r >> 1) ^ (CRC_POLY_REFL & {CRC_W{r[0] ^ d[i]}});
    return r;
  endfunction

  assign crcBase  = strobe.initCrc ? '1 : crcReg;
  assign crcNext  = crcByte(crcBase, byteData);
  assign addrNext = {byteData, addrReg[ADDR_W-1:BYTE_W]};
  assign hashIdx  = crcNext[CRC_W-1 -: HASH_BITS];
  assign bitSel   = hashIdx[SEL_W-1:0];
  assign isGroup  = addrNext[0];
  assign uniHit   = hashIdx[HASH_BITS-1] ? uniHashHi[bitSel] : uniHashLo[bitSel];
  assign mcHit    = hashIdx[HASH_BITS-1] ? mcHashHi[bitSel]  : mcHashLo[bitSel];

  always_comb begin
    if (promiscEn)                 verdict = 1'b1;
    else if (!isGroup)             verdict = (addrNext == stationAddr) || uniHit;
    else if (&addrNext)            verdict = !bcastReject;
    else if (addrNext == PAUSE_ADDR) verdict = flowCtrlEn;
    else                           verdict = mcHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcReg    <= '1;
      addrReg   <= '0;
      decValid  <= 1'b0;
      decAccept <= 1'b0;
    end else begin
      decValid <= strobe.lastByte;
      if (strobe.shiftByte) begin
        crcReg  <= crcNext;
        addrReg <= addrNext;
      end
      if (strobe.lastByte) decAccept <= verdict;
    end
  end

  // R7: promiscuous mode always keeps the frame
  p_promisc_r7: assert property (@(posedge clk) disable iff (!rstN)
    decValid && $past(promiscEn) |-> decAccept);

  // R6: a rejected broadcast is never kept
  p_bcast_rej_r6: assert property (@(posedge clk) disable iff (!rstN)
    decValid && !$past(promiscEn) && $past(bcastReject) && (&addrReg) |-> !decAccept);

  // R5: pause address without flow control is flushed
  p_pause_off_r5: assert property (@(posedge clk) disable iff (!rstN)
    decValid && !$past(promiscEn) && !$past(flowCtrlEn) && addrReg == PAUSE_ADDR
    |-> !decAccept);

  // R4: station address always kept
  p_exact_r4: assert property (@(posedge clk) disable iff (!rstN)
    decValid && !addrReg[0] && addrReg == $past(stationAddr) |-> decAccept);
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rx_filt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        byteValid,
  input  logic        sof,
  input  logic [7:0]  byteData,
  input  logic [47:0] stationAddr,
  input  logic [31:0] uniHashHi,
  input  logic [31:0] uniHashLo,
  input  logic [31:0] mcHashHi,
  input  logic [31:0] mcHashLo,
  input  logic        flowCtrlEn,
  input  logic        bcastReject,
  input  logic        promiscEn,
  output logic        decValid,
  output logic        decAccept
);
  filt_strobe_t strobe;

  rx_filt_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .byteValid (byteValid),
    .sof       (sof),
    .strobe    (strobe)
  );

  rx_filt_dp u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .byteData    (byteData),
    .stationAddr (stationAddr),
    .uniHashHi   (uniHashHi),
    .uniHashLo   (uniHashLo),
    .mcHashHi    (mcHashHi),
    .mcHashLo    (mcHashLo),
    .flowCtrlEn  (flowCtrlEn),
    .bcastReject (bcastReject),
    .promiscEn   (promiscEn),
    .decValid    (decValid),
    .decAccept   (decAccept)
  );

  // R8: the decision strobe never lasts two cycles
  p_one_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    decValid |=> !decValid);
endmodule

// File: tb/tb_rx_addr_filter.sv
module tb_rx_addr_filter;
  logic        clk = 1'b0;
  logic        rstN;
  logic        byteValid, sof;
  logic [7:0]  byteData;
  logic [47:0] stationAddr;
  logic [31:0] uniHashHi, uniHashLo, mcHashHi, mcHashLo;
  logic        flowCtrlEn, bcastReject, promiscEn;
  logic        decValid, decAccept;

  int checks = 0, fails = 0, cycles = 0;
  bit expValid = 0, expAcc = 0;
  string expTag = "R8";

  always #2 clk = ~clk;

  rx_addr_filter dut (.*);

  function automatic int hashOf(input logic [47:0] a);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int b = 0; b < 6; b++)
      for (int i = 0; i < 8; i++) begin
        bit fb = c[0] ^ a[8*b + i];
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB88320;
      end
    return int'(c >> 26);
  endfunction

  function automatic bit lookUp(input logic [31:0] hi, input logic [31:0] lo, input int h);
    return (h >= 32) ? hi[h-32] : lo[h];
  endfunction

  function automatic bit refAccept(input logic [47:0] a);
    int h = hashOf(a);
    if (promiscEn) return 1;
    if (!a[0]) return (a == stationAddr) || lookUp(uniHashHi, uniHashLo, h);
    if (a == 48'hFFFFFFFFFFFF) return !bcastReject;
    if (a == 48'h010000C28001) return flowCtrlEn;
    return lookUp(mcHashHi, mcHashLo, h);
  endfunction

  task automatic tick();
    @(negedge clk);
    checks++;
    if (decValid !== expValid || (expValid && decAccept !== expAcc)) begin
      fails++;
      $display("FAIL %s: valid/accept actual %b/%b expected %b/%b", expTag,
               decValid, decAccept, expValid, expAcc);
    end
    expValid = 0;
    expTag = "R8";
  endtask

  task automatic idle(input int n);
    byteValid = 0; sof = 0;
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic sendAddr(input logic [47:0] a, input int gapMax, input string tag);
    for (int b = 0; b < 6; b++) begin
      if (gapMax > 0) idle($urandom_range(gapMax, 0));
      byteValid = 1; sof = (b == 0); byteData = a[8*b +: 8];
      if (b == 5) begin expValid = 1; expAcc = refAccept(a); expTag = tag; end
      tick();
    end
    idle(1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog R8: actual %0d cycles expected < 100000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [47:0] a;
    rstN = 0; byteValid = 0; sof = 0; byteData = 0;
    stationAddr = 48'h665544332210;
    {uniHashHi, uniHashLo, mcHashHi, mcHashLo} = '0;
    flowCtrlEn = 0; bcastReject = 0; promiscEn = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    idle(3);                                        // R8 reset state

    sendAddr(stationAddr, 0, "R4 exact");
    sendAddr(stationAddr ^ 48'h100, 0, "R4 miss");
    a = 48'h123456789A02;
    if (hashOf(a) >= 32) uniHashHi[hashOf(a)-32] = 1; else uniHashLo[hashOf(a)] = 1;
    sendAddr(a, 0, "R3 uni set");
    {uniHashHi, uniHashLo} = '0; {mcHashHi, mcHashLo} = '1;
    sendAddr(a, 0, "R3 uni clear");
    sendAddr(stationAddr | 48'h1, 0, "R1 group not exact");
    {mcHashHi, mcHashLo} = '0;
    sendAddr(stationAddr | 48'h1, 0, "R1 group table");

    for (int k = 0; k < 200; k++) begin
      {uniHashHi, uniHashLo, mcHashHi, mcHashLo} = {$urandom, $urandom, $urandom, $urandom};
      a = {$urandom, $urandom};
      a[0] = k[0];
      sendAddr(a, 0, "R2 random hash");
    end

    {mcHashHi, mcHashLo} = '1; flowCtrlEn = 1;
    sendAddr(48'h010000C28001, 0, "R5 pause on");
    flowCtrlEn = 0;
    sendAddr(48'h010000C28001, 0, "R5 pause off");
    {mcHashHi, mcHashLo} = '0;
    sendAddr('1, 0, "R6 bcast kept");
    bcastReject = 1; {mcHashHi, mcHashLo} = '1;
    sendAddr('1, 0, "R6 bcast rejected");
    bcastReject = 0;

    {uniHashHi, uniHashLo, mcHashHi, mcHashLo} = '0; promiscEn = 1;
    for (int k = 0; k < 10; k++) begin
      a = {$urandom, $urandom};
      sendAddr(a, 0, "R7 promiscuous");
    end
    promiscEn = 0;

    for (int k = 0; k < 30; k++) begin
      {uniHashHi, uniHashLo, mcHashHi, mcHashLo} = {$urandom, $urandom, $urandom, $urandom};
      a = {$urandom, $urandom};
      sendAddr(a, 3, "R10 gaps");
    end

    byteValid = 1; sof = 1; byteData = 8'hAA; tick();
    sof = 0; tick(); tick();                        // R9 aborted address, no decision
    sendAddr(stationAddr, 0, "R9 restart");
    byteValid = 1; sof = 0;
    for (int i = 0; i < 8; i++) begin byteData = 8'($urandom); tick(); end   // R9 trailing bytes
    idle(4);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule